// File: doc/BRIEF.md
# Context-Dependent Effective Address Selector

This unit forms the final word address of a memory operand for a 32-bit processor. The address rule depends on three things: the class of the instruction, whether the instruction is running from a trap or interrupt vector location, and the mapping bit of the status word. From these it decides whether the index register is added and whether the result passes through the page map. For one instruction class it also trims the address to a narrow width.

An operation starts with a one-cycle `start` pulse. All operand fields are captured on that edge. A direct operation returns its result one cycle later. If `indirect` is set, the unit first requests the indirect word. It holds `ind_req` until `ind_valid` arrives, then returns the result computed from that word one cycle later. Only one level of indirection is followed. The page map and memory timing are outside this unit.

Class encoding on `cls`:
- 0: standard
- 1: stack push or status exchange
- 2: modify-and-test
- 3: direct I/O read or write

Top module: `ea_select`

## Requirements
- R1: While reset is held and just after it, `done`, `ind_req` and `busy` are all 0.
- R2: A `start` with `indirect`=0, taken while `busy`=0, gives `done`=1 for exactly one cycle, in the cycle after the capturing edge. `addr_o` and `map_o` are valid in that cycle.
- R3: In class 0, and in any class with `vec_ctx`=0 (other than class 3), `addr_o` is the base plus the low 20 bits of `ix_val`, modulo 2^20. A zero `ix_sel` adds nothing. `map_o` equals `map_en`.
- R4: Class 1 with `vec_ctx`=1 adds no index whatever `ix_sel` is. `map_o` equals `map_en`.
- R5: Class 2 with `vec_ctx`=1 and `vec_int`=1 adds no index. `map_o` is 1 only when both `map_en` and `ctr4` are 1.
- R6: Class 2 with `vec_ctx`=1 and `vec_int`=0 adds no index. `map_o` equals `map_en`. When `map_en`=1, address bits 14 to 12 are forced to zero; when `map_en`=0 the address is left whole.
- R7: Class 3, in any context, adds the index to the low 17 bits of the base, keeps the low 16 bits of that 17-bit sum, and zeroes bits 19 to 16. `map_o` is 0.
- R8: With `indirect`=1:
  - `ind_req` rises in the cycle after the capturing edge and stays high until an edge that sees `ind_valid`.
  - `ind_addr` is `ref_addr`, masked as in R6 when R6 applies.
  - `ind_map` equals `map_en`, except in the R5 case, where it follows the R5 rule.
  - `done` follows in the cycle after `ind_valid` is seen. The base is then the low 20 bits of `ind_word`, handled by the class rules above.
- R9: A `start` that arrives while `busy`=1 is ignored. It neither alters the result in progress nor produces an extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an address calculation |
| cls | input | 2 | Instruction class (0 std, 1 push/exchange, 2 modify-and-test, 3 direct I/O) |
| vec_ctx | input | 1 | Executing from a trap or interrupt location |
| vec_int | input | 1 | With vec_ctx: 1 interrupt, 0 trap |
| map_en | input | 1 | Status-word mapping bit |
| ctr4 | input | 1 | Instruction belongs to interrupt counter 4 |
| ix_sel | input | 3 | Index register designator, zero for none |
| indirect | input | 1 | Indirect addressing requested |
| ref_addr | input | 20 | Reference address from the instruction |
| ix_val | input | 32 | Contents of the selected index register |
| ind_word | input | 32 | Fetched indirect word |
| ind_valid | input | 1 | Indirect word present this cycle |
| busy | output | 1 | Operation in progress |
| ind_req | output | 1 | Request for the indirect word |
| ind_addr | output | 20 | Address of the indirect word |
| ind_map | output | 1 | Indirect fetch goes through the map |
| done | output | 1 | Final address valid |
| addr_o | output | 20 | Final address |
| map_o | output | 1 | Final address goes through the map |

## Verification
The assertions take for granted that the operand fields are stable on the edge where `start` is taken. They also assume that `ind_valid` is only ever raised while `ind_req` is high, because the unit ignores any strobe that comes outside a fetch. The stimulus drives every input on the falling edge and pulses `start` only when `busy` is low. The one exception is the deliberate R9 case, which pulses `start` during a pending fetch. `ind_valid` is raised only after `ind_req` has been seen high.

// File: rtl/ea_pkg.sv
package ea_pkg;
   typedef enum logic [1:0] {
      CLS_STD  = 2'd0,
      CLS_PUSH = 2'd1,
      CLS_MODT = 2'd2,
      CLS_DIO  = 2'd3
   } ea_class_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_DONE  = 2'd2
   } ea_state_e;

   typedef struct packed {
      logic ix_en;    // add index register
      logic map_fin;  // final address mapped
      logic map_ind;  // indirect fetch mapped
      logic mt_mask;  // clear the ignored field
      logic dio;      // narrow direct I/O form
   } ea_policy_t;
endpackage

// File: rtl/ea_policy.sv
module ea_policy
   import ea_pkg::*;
(
   input  ea_class_e  cls,
   input  logic       vec_ctx,
   input  logic       vec_int,
   input  logic       map_en,
   input  logic       ctr4,
   input  logic       ixd_nz,
   output ea_policy_t pol
);
   always_comb begin
      pol.ix_en   = ixd_nz;
      pol.map_fin = map_en;
      pol.map_ind = map_en;
      pol.mt_mask = 1'b0;
      pol.dio     = 1'b0;
      unique case (cls)
         CLS_PUSH: begin
            if (vec_ctx) pol.ix_en = 1'b0;
         end
         CLS_MODT: begin
            if (vec_ctx) begin
               pol.ix_en = 1'b0;
               if (vec_int) begin
                  pol.map_fin = map_en & ctr4;
                  pol.map_ind = map_en & ctr4;
               end else begin
                  pol.mt_mask = map_en;
               end
            end
         end
         CLS_DIO: begin
            pol.dio     = 1'b1;
            pol.map_fin = 1'b0;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/ea_addgen.sv
module ea_addgen
   import ea_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int DIO_IX_W  = 17,
   parameter int DIO_OUT_W = 16,
   parameter int MASK_LO   = 12,
   parameter int MASK_HI   = 14
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] ref_q,
   input  logic [ADDR_W-1:0] ixv,
   input  ea_policy_t        pol,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] fetch_addr
);
   logic [ADDR_W-1:0]   keep;
   logic [ADDR_W-1:0]   addend;
   logic [ADDR_W-1:0]   full;
   logic [DIO_IX_W-1:0] dsum;
   logic                unused_carry;

   for (genvar b = 0; b < ADDR_W; b++) begin : g_keep
      if (b >= MASK_LO && b <= MASK_HI) begin : g_clr
         assign keep[b] = 1'b0;
      end else begin : g_set
         assign keep[b] = 1'b1;
      end
   end

   assign unused_carry = ^dsum[DIO_IX_W-1:DIO_OUT_W];

   always_comb begin
      addend     = pol.ix_en ? ixv : '0;
      full       = base + addend;
      dsum       = base[DIO_IX_W-1:0] + addend[DIO_IX_W-1:0];
      fetch_addr = pol.mt_mask ? (ref_q & keep) : ref_q;
      if (pol.dio)
         addr = ADDR_W'(dsum[DIO_OUT_W-1:0]);
      else if (pol.mt_mask)
         addr = full & keep;
      else
         addr = full;
   end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
   import ea_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      indirect,
   input  logic      ind_valid,
   output ea_state_e state,
   output logic      load_op,
   output logic      load_ind
);
   ea_state_e nxt;

   assign load_op  = (state == ST_IDLE) && start;
   assign load_ind = (state == ST_FETCH) && ind_valid;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (start) nxt = indirect ? ST_FETCH : ST_DONE;
         ST_FETCH: if (ind_valid) nxt = ST_DONE;
         ST_DONE:  nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
endmodule

// File: rtl/ea_select.sv
module ea_select
   import ea_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 32,
   parameter int IXD_W     = 3,
   parameter int DIO_IX_W  = 17,
   parameter int DIO_OUT_W = 16,
   parameter int MASK_LO   = 12,
   parameter int MASK_HI   = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        cls,
   input  logic              vec_ctx,
   input  logic              vec_int,
   input  logic              map_en,
   input  logic              ctr4,
   input  logic [IXD_W-1:0]  ix_sel,
   input  logic              indirect,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [DATA_W-1:0] ix_val,
   input  logic [DATA_W-1:0] ind_word,
   input  logic              ind_valid,
   output logic              busy,
   output logic              ind_req,
   output logic [ADDR_W-1:0] ind_addr,
   output logic              ind_map,
   output logic              done,
   output logic [ADDR_W-1:0] addr_o,
   output logic              map_o
);
   initial begin
      assert (DATA_W > ADDR_W && DIO_IX_W <= ADDR_W && DIO_OUT_W < DIO_IX_W)
         else $error("ea_select: width parameters inconsistent");
      assert (MASK_LO <= MASK_HI && MASK_HI < ADDR_W)
         else $error("ea_select: ignored field outside address");
   end

   ea_state_e         state;
   logic              load_op, load_ind;
   ea_class_e         cls_q;
   logic              vctx_q, vint_q, men_q, c4_q, ixnz_q;
   logic [ADDR_W-1:0] ixv_q, ref_q, base_q;
   ea_policy_t        pol;
   logic              unused_hi;

   assign unused_hi = ^{ix_val[DATA_W-1:ADDR_W], ind_word[DATA_W-1:ADDR_W]};

   ea_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .indirect(indirect),
      .ind_valid(ind_valid), .state(state), .load_op(load_op), .load_ind(load_ind)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls_q  <= CLS_STD;
         vctx_q <= 1'b0;
         vint_q <= 1'b0;
         men_q  <= 1'b0;
         c4_q   <= 1'b0;
         ixnz_q <= 1'b0;
         ixv_q  <= '0;
         ref_q  <= '0;
         base_q <= '0;
      end else if (load_op) begin
         cls_q  <= ea_class_e'(cls);
         vctx_q <= vec_ctx;
         vint_q <= vec_int;
         men_q  <= map_en;
         c4_q   <= ctr4;
         ixnz_q <= |ix_sel;
         ixv_q  <= ix_val[ADDR_W-1:0];
         ref_q  <= ref_addr;
         base_q <= ref_addr;
      end else if (load_ind) begin
         base_q <= ind_word[ADDR_W-1:0];
      end
   end

   ea_policy u_pol (
      .cls(cls_q), .vec_ctx(vctx_q), .vec_int(vint_q), .map_en(men_q),
      .ctr4(c4_q), .ixd_nz(ixnz_q), .pol(pol)
   );

   ea_addgen #(
      .ADDR_W(ADDR_W), .DIO_IX_W(DIO_IX_W), .DIO_OUT_W(DIO_OUT_W),
      .MASK_LO(MASK_LO), .MASK_HI(MASK_HI)
   ) u_add (
      .base(base_q), .ref_q(ref_q), .ixv(ixv_q), .pol(pol),
      .addr(addr_o), .fetch_addr(ind_addr)
   );

   assign busy    = (state != ST_IDLE);
   assign ind_req = (state == ST_FETCH);
   assign done    = (state == ST_DONE);
   assign ind_map = pol.map_ind;
   assign map_o   = pol.map_fin;
endmodule

// File: rtl/ea_select_chk.sv
module ea_select_chk
   import ea_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 32,
   parameter int IXD_W     = 3,
   parameter int DIO_OUT_W = 16,
   parameter int MASK_LO   = 12,
   parameter int MASK_HI   = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [1:0]        cls,
   input logic              vec_ctx,
   input logic              vec_int,
   input logic              map_en,
   input logic              ctr4,
   input logic              indirect,
   input logic              ind_valid,
   input logic              busy,
   input logic              ind_req,
   input logic              done,
   input logic [ADDR_W-1:0] addr_o,
   input logic              map_o
);
   logic take;
   assign take = start && !busy;

   a_r2_direct_done: assert property (@(posedge clk) disable iff (!rst_n)
      take && !indirect |=> done);

   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r5_int_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      take && !indirect && cls == CLS_MODT && vec_ctx && vec_int && !ctr4 |=> !map_o);

   a_r6_field_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      take && !indirect && cls == CLS_MODT && vec_ctx && !vec_int && map_en
      |=> addr_o[MASK_HI:MASK_LO] == '0);

   a_r7_dio_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      take && !indirect && cls == CLS_DIO |=> !map_o && addr_o[ADDR_W-1:DIO_OUT_W] == '0);

   a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ind_req && !ind_valid |=> ind_req && !done);

   a_r8_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
      ind_req && ind_valid |=> done && !ind_req);

   a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      done && start |=> !busy);
endmodule

bind ea_select ea_select_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IXD_W(IXD_W), .DIO_OUT_W(DIO_OUT_W),
   .MASK_LO(MASK_LO), .MASK_HI(MASK_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .cls(cls), .vec_ctx(vec_ctx),
   .vec_int(vec_int), .map_en(map_en), .ctr4(ctr4), .indirect(indirect),
   .ind_valid(ind_valid), .busy(busy), .ind_req(ind_req), .done(done),
   .addr_o(addr_o), .map_o(map_o)
);

// File: tb/sim_ea_select.sv
`timescale 1ns/1ps
module sim_ea_select;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  cls = '0;
   logic        vec_ctx = 1'b0, vec_int = 1'b0, map_en = 1'b0, ctr4 = 1'b0;
   logic [2:0]  ix_sel = '0;
   logic        indirect = 1'b0;
   logic [19:0] ref_addr = '0;
   logic [31:0] ix_val = '0;
   logic [31:0] ind_word = '0;
   logic        ind_valid = 1'b0;
   logic        busy, ind_req, ind_map, done, map_o;
   logic [19:0] ind_addr, addr_o;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   ea_select u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cls(cls), .vec_ctx(vec_ctx),
      .vec_int(vec_int), .map_en(map_en), .ctr4(ctr4), .ix_sel(ix_sel),
      .indirect(indirect), .ref_addr(ref_addr), .ix_val(ix_val),
      .ind_word(ind_word), .ind_valid(ind_valid), .busy(busy), .ind_req(ind_req),
      .ind_addr(ind_addr), .ind_map(ind_map), .done(done), .addr_o(addr_o),
      .map_o(map_o)
   );

   typedef struct packed {
      logic [1:0]  c;
      logic        vc;
      logic        vi;
      logic        me;
      logic        c4;
      logic [2:0]  ixs;
      logic [19:0] ra;
      logic [31:0] ixv;
      logic [19:0] ea;
      logic        mp;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VT [NV] = '{
      '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 20'h12345, 32'h00000010, 20'h12355, 1'b0}, // R3
      '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 20'h12345, 32'h000FFFFF, 20'h12345, 1'b1}, // R3 zero designator
      '{2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 20'hFFFF0, 32'h00000020, 20'h00010, 1'b1}, // R3 wrap
      '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 20'h00400, 32'h00000100, 20'h00400, 1'b1}, // R4 trap
      '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd5, 20'h0ABCD, 32'h00000007, 20'h0ABCD, 1'b0}, // R4 intr
      '{2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 20'h00400, 32'h00000100, 20'h00500, 1'b1}, // R3 push normal
      '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 3'd1, 20'h07123, 32'h00000005, 20'h07123, 1'b0}, // R5
      '{2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 3'd1, 20'h07123, 32'h00000005, 20'h07123, 1'b1}, // R5 ctr4
      '{2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1, 20'h07123, 32'h00000005, 20'h00123, 1'b1}, // R6 mapped
      '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 20'h07123, 32'h00000005, 20'h07123, 1'b0}, // R6 unmapped
      '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 20'h07123, 32'h00000005, 20'h07128, 1'b1}, // R3 mt normal
      '{2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 20'h0FFFF, 32'h00000001, 20'h00000, 1'b0}, // R7 trunc
      '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 20'hABCDE, 32'h00000000, 20'h0BCDE, 1'b0}, // R7 no index
      '{2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2, 20'h01000, 32'h00000010, 20'h01010, 1'b0}  // R7 vector ctx
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] c, input logic vc, input logic vi, input logic me,
                        input logic c4, input logic [2:0] ixs, input logic ind,
                        input logic [19:0] ra, input logic [31:0] ixv);
      @(negedge clk);
      cls = c; vec_ctx = vc; vec_int = vi; map_en = me; ctr4 = c4;
      ix_sel = ixs; indirect = ind; ref_addr = ra; ix_val = ixv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic supply(input logic [31:0] w);
      ind_word = w;
      ind_valid = 1'b1;
      @(negedge clk);
      ind_valid = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 done", 32'(done), 32'd0);
      chk("R1 ind_req", 32'(ind_req), 32'd0);
      chk("R1 busy", 32'(busy), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after release", 32'(busy), 32'd0);

      for (int i = 0; i < NV; i++) begin
         issue(VT[i].c, VT[i].vc, VT[i].vi, VT[i].me, VT[i].c4, VT[i].ixs, 1'b0,
               VT[i].ra, VT[i].ixv);
         chk($sformatf("R2 done vec%0d", i), 32'(done), 32'd1);
         chk($sformatf("addr vec%0d", i), 32'(addr_o), 32'(VT[i].ea));
         chk($sformatf("map vec%0d", i), 32'(map_o), 32'(VT[i].mp));
         @(negedge clk);
         chk($sformatf("R2 single pulse vec%0d", i), 32'(done), 32'd0);
      end

      // R8 standard indirect with index after fetch
      issue(2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b1, 20'h00200, 32'h00000010);
      chk("R8 ind_req", 32'(ind_req), 32'd1);
      chk("R8 ind_addr", 32'(ind_addr), 32'h00200);
      chk("R8 ind_map", 32'(ind_map), 32'd1);
      chk("R8 no early done", 32'(done), 32'd0);
      repeat (2) @(negedge clk);
      chk("R8 ind_req held", 32'(ind_req), 32'd1);
      supply(32'hFFF01234);
      chk("R8 done", 32'(done), 32'd1);
      chk("R8 addr", 32'(addr_o), 32'h01244);
      chk("R8 map", 32'(map_o), 32'd1);
      @(negedge clk);
      chk("R8 req dropped", 32'(ind_req), 32'd0);

      // R8 with R7: direct I/O indirect, fetch mapped, result narrow
      issue(2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b1, 20'h00300, 32'h00000002);
      chk("R8 dio ind_map", 32'(ind_map), 32'd1);
      chk("R8 dio ind_addr", 32'(ind_addr), 32'h00300);
      supply(32'h0002FFFF);
      chk("R7 dio ind addr", 32'(addr_o), 32'h00001);
      chk("R7 dio ind map", 32'(map_o), 32'd0);

      // R8 with R6: modify-and-test trap, mapped, fetch address masked
      issue(2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 20'h05040, 32'h0);
      chk("R6 masked ind_addr", 32'(ind_addr), 32'h00040);
      supply(32'h00007777);
      chk("R6 masked final", 32'(addr_o), 32'h00777);

      // R4 + R9: push from trap, stray start during fetch
      issue(2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd4, 1'b1, 20'h00080, 32'h00001000);
      chk("R4 ind_addr", 32'(ind_addr), 32'h00080);
      issue(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 20'h0AAAA, 32'h00000001);
      chk("R9 still fetching", 32'(ind_req), 32'd1);
      chk("R9 no done", 32'(done), 32'd0);
      supply(32'h00000555);
      chk("R9 done", 32'(done), 32'd1);
      chk("R4 ind no index", 32'(addr_o), 32'h00555);
      chk("R9 map kept", 32'(map_o), 32'd1);
      @(negedge clk);
      chk("R9 idle", 32'(busy), 32'd0);
      @(negedge clk);
      chk("R9 no extra done", 32'(done), 32'd0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule